// File: doc/BRIEF.md
# ECC Error Capture and Reporting Unit

This unit sits next to a memory read path that a single-error-correct, double-error-detect code protects. On every cycle it sees the decoder's two outcome flags (corrected and uncorrectable), the address of the access, and a qualifier that marks the access as speculative, meaning fetched ahead but never consumed. It turns these into four things:

- one-cycle event pulses toward a system error aggregator;
- an active-low external fault pin;
- a bus abort for faulty data that is actually consumed;
- a pair of address capture registers that software can read.

Each capture register locks on the first error of its class. It then ignores later errors of that class until software reads the locked address. A speculative fetch that hits a bad word still reports the error, but it never aborts. Every uncorrectable error drives the fault pin low, and the pin stays low until a minimum time has passed and software writes an unlock key. One control bit turns off correction. When it is set, a consumed correctable error aborts as well.

The register window has 3-bit word indices:

| Index | Register | Contents |
|-------|----------|----------|
| 0 | Control | Bit 0 is the correction-off bit. |
| 1 | Status | Bit 0 is the sticky corrected flag. Bit 1 is the sticky uncorrectable flag. Bit 16 is the corrected-capture lock. Bit 18 is the uncorrectable-capture lock. |
| 2 | Corrected capture | The locked corrected-error address. |
| 3 | Uncorrectable capture | The locked uncorrectable-error address. |
| 4 | Pin unlock | Write-only; reads return 0. |

Read data appears on `reg_rdata` in the cycle after `reg_rd`. All outputs are registered, so each reacts one cycle after the input that causes it.

Top module: `ecc_err_capture`

## Requirements
- R1: After synchronous reset, `abort_o`, `flag_corr_o` and `flag_uncorr_o` are 0, `err_pin_n_o` is 1, and registers 0 to 4 all read as 0.
- R2: `flag_corr_o` / `flag_uncorr_o` pulse high in the cycle after an access with `acc_valid`=1 and `err_corr` / `err_uncorr` set, whether speculative or not. Error inputs are ignored when `acc_valid`=0.
- R3: A valid access with `err_uncorr`=1 and `acc_spec`=0 raises `abort_o` the next cycle. Any access with `acc_spec`=1 never raises `abort_o`.
- R4: A correctable error does not abort while control bit 0 is 0. With control bit 0 set to 1, a valid non-speculative correctable error aborts the next cycle.
- R5: The first error of a class loads its capture register (index 2 corrected, index 3 uncorrectable) with `acc_addr`. It also sets that class's lock bit in status (bit 16 corrected, bit 18 uncorrectable). Speculative errors are captured too.
- R6: While a class is locked, further errors of that class leave its captured address unchanged.
- R7: A read of a capture register returns the locked address and clears that class's lock. An error arriving in the same cycle as that read is captured and relocks the class, and the read still returns the old address.
- R8: A correctable and an uncorrectable error in the same cycle load both capture registers, each subject only to its own lock.
- R9: Every valid uncorrectable error, speculative or not, drives `err_pin_n_o` low the next cycle.
- R10: Once `err_pin_n_o` goes low, it returns high only on a write of `CLR_KEY` to index 4 issued at least `PIN_MIN` cycles after the error edge. An earlier write or any other value is ignored. A new uncorrectable error restarts the minimum time.
- R11: Status bits 0 and 1 are write-one-to-clear, and writing 0 to them has no effect. Bits 16 and 18 are read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A read access completes this cycle |
| acc_spec | input | 1 | Access was speculative and not consumed |
| err_corr | input | 1 | Decoder corrected a single-bit error |
| err_uncorr | input | 1 | Decoder found an uncorrectable error |
| acc_addr | input | ADDR_W | Address of the access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| abort_o | output | 1 | Bus abort for the access of the previous cycle |
| flag_corr_o | output | 1 | Corrected-error event to the error aggregator |
| flag_uncorr_o | output | 1 | Uncorrectable-error event to the error aggregator |
| err_pin_n_o | output | 1 | Active-low external fault pin |

## Verification
The bench sweeps every combination of speculative qualifier, both error flags and the correction-off bit. This catches a design that aborts on a speculative fetch, or that drops the aggregator event when the abort is suppressed.

It repeats locked captures over several addresses for both classes. It also covers a read that coincides with a new error and a simultaneous error of both classes. A design that overwrites on a later error, loses the coincident error, or lets one class's lock block the other would return a wrong address.

The unlock write is swept across each delay around `PIN_MIN` and is also tried with a wrong key. A pin that releases one cycle early, or on any write, is exposed.

Writes of zero, of single bits and of the lock bits to status show whether the flags clear only on ones and whether the locks can be written.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RI_CTRL   = 3'd0,
    RI_STAT   = 3'd1,
    RI_CADDR  = 3'd2,
    RI_UADDR  = 3'd3,
    RI_PINCLR = 3'd4
  } reg_idx_e;

  // status bit positions
  localparam int ST_CFLAG = 0;
  localparam int ST_UFLAG = 1;
  localparam int ST_CLOCK = 16;
  localparam int ST_ULOCK = 18;

  // error classes
  localparam int CLS_CORR = 0;
  localparam int CLS_UNC  = 1;
  localparam int N_CLS    = 2;
endpackage

// File: rtl/ecc_err_capt_reg.sv
module ecc_err_capt_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic              rel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              lock_o
);
  // A release and a new hit in the same cycle: the hit wins and relocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      lock_o <= 1'b0;
    end else if (hit_i && (!lock_o || rel_i)) begin
      addr_o <= addr_i;
      lock_o <= 1'b1;
    end else if (rel_i) begin
      lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_err_pin_ctrl.sv
module ecc_err_pin_ctrl #(
  parameter int MIN_LOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic clr_i,
  output logic pin_n_o
);
  localparam int CNT_W = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(MIN_LOW - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_n_o <= 1'b1;
      cnt_q   <= '0;
    end else if (trig_i) begin
      pin_n_o <= 1'b0;
      cnt_q   <= LOAD;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      if (clr_i && !pin_n_o && (cnt_q == '0)) pin_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_err_regif.sv
module ecc_err_regif
  import ecc_err_pkg::*;
#(
  parameter int          ADDR_W  = 20,
  parameter logic [31:0] CLR_KEY = 32'h0000_5EC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              set_c_i,
  input  logic              set_u_i,
  input  logic [ADDR_W-1:0] caddr_i,
  input  logic [ADDR_W-1:0] uaddr_i,
  input  logic              clock_i,
  input  logic              ulock_i,
  output logic [31:0]       reg_rdata,
  output logic              no_corr_o,
  output logic [N_CLS-1:0]  rel_o,
  output logic              key_o
);
  logic [1:0]  flag_q;
  logic [1:0]  w1c;
  logic [31:0] stat_v;
  logic [31:0] rd_v;

  assign w1c   = (reg_wr && reg_addr == RI_STAT) ? reg_wdata[1:0] : 2'b00;
  assign key_o = reg_wr && (reg_addr == RI_PINCLR) && (reg_wdata == CLR_KEY);

  assign rel_o[CLS_CORR] = reg_rd && (reg_addr == RI_CADDR);
  assign rel_o[CLS_UNC]  = reg_rd && (reg_addr == RI_UADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= '0;
      no_corr_o <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~w1c) | {set_u_i, set_c_i};
      if (reg_wr && reg_addr == RI_CTRL) no_corr_o <= reg_wdata[0];
    end
  end

  always_comb begin
    stat_v           = '0;
    stat_v[ST_CFLAG] = flag_q[0];
    stat_v[ST_UFLAG] = flag_q[1];
    stat_v[ST_CLOCK] = clock_i;
    stat_v[ST_ULOCK] = ulock_i;
    rd_v = '0;
    case (reg_addr)
      RI_CTRL:  rd_v[0] = no_corr_o;
      RI_STAT:  rd_v = stat_v;
      RI_CADDR: rd_v[ADDR_W-1:0] = caddr_i;
      RI_UADDR: rd_v[ADDR_W-1:0] = uaddr_i;
      default:  rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_v;
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_err_pkg::*;
#(
  parameter int          ADDR_W  = 20,
  parameter int          PIN_MIN = 16,
  parameter logic [31:0] CLR_KEY = 32'h0000_5EC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_spec,
  input  logic              err_corr,
  input  logic              err_uncorr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              abort_o,
  output logic              flag_corr_o,
  output logic              flag_uncorr_o,
  output logic              err_pin_n_o
);
  logic              ev_c, ev_u, no_corr, key_wr;
  logic [N_CLS-1:0]  hit, rel, lock;
  logic [ADDR_W-1:0] cap_addr [N_CLS];
  logic [ADDR_W-1:0] corr_addr, unc_addr;
  logic              corr_lock, unc_lock;

  assign ev_c = acc_valid && err_corr;
  assign ev_u = acc_valid && err_uncorr;

  assign hit[CLS_CORR] = ev_c;
  assign hit[CLS_UNC]  = ev_u;

  for (genvar g = 0; g < N_CLS; g++) begin : g_cap
    ecc_err_capt_reg #(.ADDR_W(ADDR_W)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .hit_i  (hit[g]),
      .rel_i  (rel[g]),
      .addr_i (acc_addr),
      .addr_o (cap_addr[g]),
      .lock_o (lock[g])
    );
  end

  assign corr_addr = cap_addr[CLS_CORR];
  assign unc_addr  = cap_addr[CLS_UNC];
  assign corr_lock = lock[CLS_CORR];
  assign unc_lock  = lock[CLS_UNC];

  ecc_err_regif #(.ADDR_W(ADDR_W), .CLR_KEY(CLR_KEY)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .set_c_i   (ev_c),
    .set_u_i   (ev_u),
    .caddr_i   (corr_addr),
    .uaddr_i   (unc_addr),
    .clock_i   (corr_lock),
    .ulock_i   (unc_lock),
    .reg_rdata (reg_rdata),
    .no_corr_o (no_corr),
    .rel_o     (rel),
    .key_o     (key_wr)
  );

  ecc_err_pin_ctrl #(.MIN_LOW(PIN_MIN)) u_pin (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (ev_u),
    .clr_i   (key_wr),
    .pin_n_o (err_pin_n_o)
  );

  // Events always reach the aggregator; only consumed data may abort.
  always_ff @(posedge clk) begin
    if (rst) begin
      abort_o       <= 1'b0;
      flag_corr_o   <= 1'b0;
      flag_uncorr_o <= 1'b0;
    end else begin
      abort_o       <= !acc_spec && (ev_u || (ev_c && no_corr));
      flag_corr_o   <= ev_c;
      flag_uncorr_o <= ev_u;
    end
  end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
  parameter int ADDR_W  = 20,
  parameter int PIN_MIN = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_spec,
  input logic              err_corr,
  input logic              err_uncorr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic              abort_o,
  input logic              flag_corr_o,
  input logic              flag_uncorr_o,
  input logic              err_pin_n_o,
  input logic [ADDR_W-1:0] corr_addr,
  input logic [ADDR_W-1:0] unc_addr,
  input logic              corr_lock,
  input logic              unc_lock
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || err_pin_n_o) low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
  end

  // R3
  spec_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(acc_valid && !acc_spec));

  // R3
  unc_abort_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && acc_valid && !acc_spec && err_uncorr) |-> abort_o);

  // R2
  flag_c_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (flag_corr_o == $past(acc_valid && err_corr)));

  // R2
  flag_u_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (flag_uncorr_o == $past(acc_valid && err_uncorr)));

  // R9
  pin_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && acc_valid && err_uncorr) |-> !err_pin_n_o);

  // R10
  pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_pin_n_o) |-> (low_cnt >= 16'(PIN_MIN)));

  // R5
  c_capt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && acc_valid && err_corr && !corr_lock)
      |-> (corr_lock && corr_addr == $past(acc_addr)));

  // R6
  c_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && corr_lock && !(reg_rd && reg_addr == 3'd2))
      |-> (corr_addr == $past(corr_addr)));

  // R6
  u_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && unc_lock && !(reg_rd && reg_addr == 3'd3))
      |-> (unc_addr == $past(unc_addr)));
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.ADDR_W(ADDR_W), .PIN_MIN(PIN_MIN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .acc_spec      (acc_spec),
  .err_corr      (err_corr),
  .err_uncorr    (err_uncorr),
  .acc_addr      (acc_addr),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .abort_o       (abort_o),
  .flag_corr_o   (flag_corr_o),
  .flag_uncorr_o (flag_uncorr_o),
  .err_pin_n_o   (err_pin_n_o),
  .corr_addr     (corr_addr),
  .unc_addr      (unc_addr),
  .corr_lock     (corr_lock),
  .unc_lock      (unc_lock)
);

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb;
  localparam int          AW   = 8;
  localparam int          PMIN = 4;
  localparam logic [31:0] KEY  = 32'h0000_5EC0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 0, acc_spec = 0, err_corr = 0, err_uncorr = 0;
  logic [AW-1:0] acc_addr = '0;
  logic          reg_wr = 0, reg_rd = 0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          abort_o, flag_corr_o, flag_uncorr_o, err_pin_n_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_err_capture #(.ADDR_W(AW), .PIN_MIN(PMIN), .CLR_KEY(KEY)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_spec(acc_spec),
    .err_corr(err_corr), .err_uncorr(err_uncorr), .acc_addr(acc_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .abort_o(abort_o), .flag_corr_o(flag_corr_o),
    .flag_uncorr_o(flag_uncorr_o), .err_pin_n_o(err_pin_n_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    acc_valid = 0; acc_spec = 0; err_corr = 0; err_uncorr = 0;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic do_reset();
    idle_in();
    rst = 1;
    step();
    step();
    rst = 0;
  endtask

  task automatic acc(input logic s, input logic c, input logic u, input logic [AW-1:0] a);
    acc_valid = 1; acc_spec = s; err_corr = c; err_uncorr = u; acc_addr = a;
    step();
    acc_valid = 0; acc_spec = 0; err_corr = 0; err_uncorr = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    reg_rd = 1; reg_addr = i;
    step();
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    reg_wr = 1; reg_addr = i; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [AW-1:0] a1, a2;

    // R1 reset state
    do_reset();
    chk("R1 abort", {31'b0, abort_o}, 0);
    chk("R1 flags", {30'b0, flag_uncorr_o, flag_corr_o}, 0);
    chk("R1 pin", {31'b0, err_pin_n_o}, 1);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), d);
      chk("R1 register", d, 0);
    end

    // R2 invalid access ignored
    acc_spec = 0; err_corr = 1; err_uncorr = 1; acc_addr = 8'h77;
    step();
    err_corr = 0; err_uncorr = 0;
    chk("R2 no flags when not valid", {29'b0, abort_o, flag_uncorr_o, flag_corr_o}, 0);
    chk("R2 R9 pin unchanged when not valid", {31'b0, err_pin_n_o}, 1);
    rd(3'd1, d);
    chk("R2 status unchanged when not valid", d, 0);

    // R2 R3 R4 R9 exhaustive sweep
    for (int nc = 0; nc < 2; nc++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 2; c++)
          for (int u = 0; u < 2; u++) begin
            do_reset();
            if (nc == 1) begin
              wr(3'd0, 32'h1);
              rd(3'd0, d);
              chk("R4 control readback", d, 1);
            end
            acc(s[0], c[0], u[0], 8'h30);
            chk("R3 R4 abort", {31'b0, abort_o},
                {31'b0, (s == 0) && (u == 1 || (c == 1 && nc == 1))});
            chk("R2 corrected event", {31'b0, flag_corr_o}, {31'b0, c[0]});
            chk("R2 uncorrectable event", {31'b0, flag_uncorr_o}, {31'b0, u[0]});
            chk("R9 pin", {31'b0, err_pin_n_o}, {31'b0, ~u[0]});
          end

    // R5 R6 R7 capture and lock, both classes
    do_reset();
    for (int cls = 0; cls < 2; cls++)
      for (int k = 0; k < 4; k++) begin
        a1 = 8'(16 * k + 3 + 64 * cls);
        a2 = a1 ^ 8'h5A;
        acc(k[0], cls == 0, cls == 1, a1);
        acc(0, cls == 0, cls == 1, a2);
        rd(3'd1, d);
        chk("R5 lock bit set", (d >> (cls == 0 ? 16 : 18)) & 32'h1, 1);
        rd(3'(2 + cls), d);
        chk("R6 first address held", d, {24'b0, a1});
        rd(3'd1, d);
        chk("R7 lock released by read", (d >> (cls == 0 ? 16 : 18)) & 32'h1, 0);
        acc(0, cls == 0, cls == 1, a2);
        rd(3'(2 + cls), d);
        chk("R7 capture after release", d, {24'b0, a2});
      end

    // R7 read coinciding with a new error
    acc(0, 1, 0, 8'h11);
    reg_rd = 1; reg_addr = 3'd2;
    acc_valid = 1; err_corr = 1; acc_addr = 8'h22;
    step();
    reg_rd = 0; acc_valid = 0; err_corr = 0;
    chk("R7 coincident read returns old", reg_rdata, 32'h11);
    rd(3'd1, d);
    chk("R7 coincident error relocks", (d >> 16) & 32'h1, 1);
    rd(3'd2, d);
    chk("R7 coincident error captured", d, 32'h22);

    // R8 simultaneous classes
    do_reset();
    acc(0, 1, 1, 8'h44);
    rd(3'd1, d);
    chk("R8 both locked", d, 32'h0005_0003);
    rd(3'd2, d);
    chk("R8 corrected captured", d, 32'h44);
    acc(0, 1, 1, 8'h55);
    rd(3'd3, d);
    chk("R8 uncorrectable lock kept", d, 32'h44);
    rd(3'd2, d);
    chk("R8 corrected independent", d, 32'h55);

    // R10 unlock timing sweep
    for (int dly = 1; dly <= PMIN + 1; dly++) begin
      do_reset();
      acc(1, 0, 1, 8'h66);
      for (int j = 0; j < dly - 1; j++) step();
      wr(3'd4, KEY);
      chk("R10 unlock timing", {31'b0, err_pin_n_o}, {31'b0, dly >= PMIN});
    end
    do_reset();
    acc(0, 0, 1, 8'h67);
    repeat (PMIN) step();
    wr(3'd4, KEY ^ 32'h1);
    chk("R10 wrong key ignored", {31'b0, err_pin_n_o}, 0);
    acc(0, 0, 1, 8'h68);
    repeat (PMIN - 2) step();
    wr(3'd4, KEY);
    chk("R10 retrigger restarts time", {31'b0, err_pin_n_o}, 0);
    wr(3'd4, KEY);
    chk("R10 release after restart", {31'b0, err_pin_n_o}, 1);
    rd(3'd4, d);
    chk("R10 unlock register reads 0", d, 0);

    // R11 write-one-to-clear
    do_reset();
    acc(1, 1, 0, 8'h01);
    wr(3'd1, 32'h0);
    rd(3'd1, d);
    chk("R11 zero write no effect", d, 32'h0001_0001);
    wr(3'd1, 32'h2);
    rd(3'd1, d);
    chk("R11 other bit no effect", d, 32'h0001_0001);
    wr(3'd1, 32'h0005_0001);
    rd(3'd1, d);
    chk("R11 flag cleared lock kept", d, 32'h0001_0000);
    acc(1, 0, 1, 8'h02);
    rd(3'd1, d);
    chk("R11 uncorrectable flag set", d, 32'h0005_0002);
    wr(3'd1, 32'h2);
    rd(3'd1, d);
    chk("R11 uncorrectable flag cleared", d, 32'h0005_0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule